// File: doc/BRIEF.md
# Dual-Line Manchester Bit Receiver

This block receives a serial downstream link that arrives on two duplicated wires, of which only one carries traffic at any moment. Both wires are sampled by the system clock at four samples per bit. The block finds out by itself which wire is in use. It recovers the bit timing from the mid-bit transitions and delivers the decoded bits one at a time, each with a one-cycle strobe. It also reports when the selected wire has gone quiet.

Each bit has a transition in its middle. A rise in the middle of the bit means one and a fall means zero. A quiet wire sits low and does not change. Every transmission starts with a one, which is the first bit of its start pattern, so the first rising edge after a quiet period fixes the bit phase. After that, every mid-bit transition moves the timing reference, and the transitions at bit boundaries are thrown away. This lets the receiver follow a transmitter whose bit period differs by about ten percent. Frame parsing, checksums and transmission belong to other blocks.

Top module: `dual_manchester_rx`

## Requirements
- R1: After reset, sel_o is 0 (wire rx_line_i[0]), line_idle_o is 1, locked_o is 0 and bit_valid_o is 0.
- R2: A one is sent as low in the first half of the bit and high in the second half, so the line rises mid-bit; a zero is sent as high then low, so the line falls mid-bit. Each decoded bit gives exactly one bit_valid_o pulse of one cycle, with the bit on bit_o, in the order the bits were received.
- R3: When the receiver is not locked, the first rising transition on the selected wire is decoded as a one and sets locked_o. Falling transitions do not lock it.
- R4: Once locked, a transition that comes less than three quarters of a bit time (3 samples) after the last accepted mid-bit transition is a boundary transition and is ignored. A later transition is a mid-bit transition: it gives one bit and restarts the timing.
- R5: Decoding stays correct when single bits are shortened to 3 samples or lengthened to 5 samples by moving the mid-bit transition.
- R6: When the selected wire is idle and a transition appears on the other wire, the selection moves to that wire (sel_o gives the index). That same transition is decoded as the first bit.
- R7: While the selected wire is not idle, transitions on the other wire leave sel_o and the decoded bits unchanged.
- R8: line_idle_o rises once the selected wire has had no transition for more than 2 bit times: not before 8 and not after 14 sample periods after its last input transition. A transition on the wire clears line_idle_o, and idle also clears locked_o.
- R9: bit_valid_o is never high in two cycles in a row, and never while line_idle_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, four samples per bit |
| rst | input | 1 | Synchronous active-high reset |
| rx_line_i | input | 2 | The two duplicated serial wires (asynchronous) |
| sel_o | output | 1 | Index of the wire being decoded |
| line_idle_o | output | 1 | Selected wire has been quiet for more than 2 bit times |
| locked_o | output | 1 | Bit timing is locked |
| bit_valid_o | output | 1 | One-cycle strobe for a decoded bit |
| bit_o | output | 1 | Decoded bit value, valid with bit_valid_o |

## Verification
A table of bursts drives the decoder with several patterns. The start pattern itself comes first. All-ones bursts put a boundary transition between every pair of bits, and alternating bursts have no boundary transitions at all; comparing the two shows whether boundary edges are told apart from mid-bit edges. A single one followed by zeros checks that the timing follows falling mid-bit edges. Some bursts run on alternating wires, which checks that the selection follows the active wire. Other bursts stretch or shrink every other bit by one sample, which shows whether the timing is taken again from each mid-bit edge and not counted out from the start. Directed cases then check the reset values, a lone one bit with the idle timing window, and a pulse on the other wire in the middle of a burst, which must neither move the selection nor corrupt the bits.

// File: rtl/dmrx_pkg.sv
package dmrx_pkg;

    // Status of one received wire after synchronisation
    typedef struct packed {
        logic edge_seen;   // any transition this cycle
        logic rising;      // the transition went low to high
        logic idle;        // quiet for longer than the idle window
    } line_stat_t;

    // Earliest sample count at which a transition counts as mid-bit
    function automatic int unsigned mid_threshold(input int unsigned spb);
        return spb - spb / 4;
    endfunction

    // Samples without a transition after which a wire is idle
    function automatic int unsigned idle_limit(input int unsigned spb,
                                               input int unsigned bits);
        return spb * bits + 1;
    endfunction

endpackage

// File: rtl/dmrx_line_mon.sv
module dmrx_line_mon
    import dmrx_pkg::*;
#(
    parameter int unsigned SPB         = 4,
    parameter int unsigned IDLE_BITS   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_i,
    output line_stat_t stat_o
);
    localparam int unsigned IDLE_LIM = idle_limit(SPB, IDLE_BITS);
    localparam int unsigned IW       = $clog2(IDLE_LIM + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic [IW-1:0]          quiet_q;
    logic                   level;
    logic                   edge_now;

    assign level    = sync_q[SYNC_STAGES-1];
    assign edge_now = level ^ prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            prev_q <= level;
        end
    end

    // Quiet-time counter, saturating at the idle limit
    always_ff @(posedge clk) begin
        if (rst)
            quiet_q <= IW'(IDLE_LIM);
        else if (edge_now)
            quiet_q <= '0;
        else if (quiet_q != IW'(IDLE_LIM))
            quiet_q <= quiet_q + 1'b1;
    end

    assign stat_o.edge_seen = edge_now;
    assign stat_o.rising    = edge_now & level;
    assign stat_o.idle      = (quiet_q == IW'(IDLE_LIM));

    // R8: a transition always clears the idle flag on the next cycle
    a_r8_edge_clears_idle: assert property (@(posedge clk) disable iff (rst)
        stat_o.edge_seen |=> !stat_o.idle);

endmodule

// File: rtl/dmrx_select.sv
module dmrx_select (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] idle_i,
    input  logic [1:0] edge_i,
    output logic       sel_q,
    output logic       sel_nxt,
    output logic       restart_o
);
    logic other;
    assign other = ~sel_q;

    always_comb begin
        sel_nxt = sel_q;
        if (idle_i[sel_q] && !edge_i[sel_q] && edge_i[other])
            sel_nxt = other;
    end

    assign restart_o = (sel_nxt != sel_q);

    always_ff @(posedge clk) begin
        if (rst) sel_q <= 1'b0;
        else     sel_q <= sel_nxt;
    end

    // R7: an active selected wire keeps the selection
    a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
        !idle_i[sel_q] |=> $stable(sel_q));

endmodule

// File: rtl/dmrx_decoder.sv
module dmrx_decoder
    import dmrx_pkg::*;
#(
    parameter int unsigned SPB = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic edge_i,
    input  logic rising_i,
    input  logic idle_i,
    input  logic restart_i,
    output logic locked_o,
    output logic bit_valid_o,
    output logic bit_o
);
    localparam int unsigned MID_MIN = mid_threshold(SPB);
    localparam int unsigned CNT_MAX = 2 * SPB;
    localparam int unsigned CW      = $clog2(CNT_MAX + 1);

    logic          locked_q;
    logic [CW-1:0] since_q;
    logic          eff_locked;
    logic          mid_edge;

    assign eff_locked = locked_q & ~restart_i;
    assign mid_edge   = edge_i && eff_locked && (since_q >= CW'(MID_MIN));

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q    <= 1'b0;
            since_q     <= '0;
            bit_valid_o <= 1'b0;
            bit_o       <= 1'b0;
        end else begin
            bit_valid_o <= 1'b0;
            if (since_q != CW'(CNT_MAX))
                since_q <= since_q + 1'b1;
            if (edge_i && !eff_locked) begin
                if (rising_i) begin
                    locked_q    <= 1'b1;
                    bit_valid_o <= 1'b1;
                    bit_o       <= 1'b1;
                    since_q     <= CW'(1);
                end
            end else if (mid_edge) begin
                bit_valid_o <= 1'b1;
                bit_o       <= rising_i;
                since_q     <= CW'(1);
            end else if (!edge_i && idle_i) begin
                locked_q <= 1'b0;
            end
        end
    end

    assign locked_o = locked_q;

    // R3: acquiring lock always emits a one
    a_r3_lock_starts_with_one: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> (bit_valid_o && bit_o));

    // R9: bit strobes are single-cycle and never adjacent
    a_r9_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        bit_valid_o |=> !bit_valid_o);

endmodule

// File: rtl/dual_manchester_rx.sv
module dual_manchester_rx
    import dmrx_pkg::*;
#(
    parameter int unsigned SPB         = 4,
    parameter int unsigned IDLE_BITS   = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] rx_line_i,
    output logic       sel_o,
    output logic       line_idle_o,
    output logic       locked_o,
    output logic       bit_valid_o,
    output logic       bit_o
);
    localparam int unsigned NLINES = 2;

    line_stat_t         stat_v [NLINES];
    logic [NLINES-1:0]  edge_v;
    logic [NLINES-1:0]  rise_v;
    logic [NLINES-1:0]  idle_v;
    logic               sel_q;
    logic               sel_nxt;
    logic               restart;

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        dmrx_line_mon #(
            .SPB        (SPB),
            .IDLE_BITS  (IDLE_BITS),
            .SYNC_STAGES(SYNC_STAGES)
        ) u_mon (
            .clk   (clk),
            .rst   (rst),
            .line_i(rx_line_i[i]),
            .stat_o(stat_v[i])
        );
        assign edge_v[i] = stat_v[i].edge_seen;
        assign rise_v[i] = stat_v[i].rising;
        assign idle_v[i] = stat_v[i].idle;
    end

    dmrx_select u_sel (
        .clk      (clk),
        .rst      (rst),
        .idle_i   (idle_v),
        .edge_i   (edge_v),
        .sel_q    (sel_q),
        .sel_nxt  (sel_nxt),
        .restart_o(restart)
    );

    // The decoder follows the wire chosen this cycle, so a switching edge is not lost
    dmrx_decoder #(.SPB(SPB)) u_dec (
        .clk        (clk),
        .rst        (rst),
        .edge_i     (edge_v[sel_nxt]),
        .rising_i   (rise_v[sel_nxt]),
        .idle_i     (idle_v[sel_nxt]),
        .restart_i  (restart),
        .locked_o   (locked_o),
        .bit_valid_o(bit_valid_o),
        .bit_o      (bit_o)
    );

    assign sel_o       = sel_q;
    assign line_idle_o = idle_v[sel_q];

    // R9: no bit is reported while the selected wire is idle
    a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        line_idle_o |-> !bit_valid_o);

endmodule

// File: tb/dual_manchester_rx_test.sv
module dual_manchester_rx_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] line = 2'b00;
    logic       sel_o, line_idle_o, locked_o, bit_valid_o, bit_o;

    int n_chk  = 0;
    int n_fail = 0;
    int ng     = 0;
    logic [31:0] got = '0;

    always #10 clk = ~clk;   // 50 MHz

    dual_manchester_rx uut (
        .clk(clk), .rst(rst), .rx_line_i(line),
        .sel_o(sel_o), .line_idle_o(line_idle_o), .locked_o(locked_o),
        .bit_valid_o(bit_valid_o), .bit_o(bit_o)
    );

    // Bits are sent from bit 0 upward; stretch moves the mid-bit edge of odd bits
    localparam int NV = 8;
    localparam logic [15:0] V_BITS [NV] = '{16'h0135, 16'hFFFF, 16'h0001, 16'hAAAB,
                                            16'h5A5B, 16'h00C3, 16'hE6F1, 16'h3335};
    localparam int V_LEN  [NV] = '{9, 16, 16, 16, 16, 12, 16, 16};
    localparam int V_LINE [NV] = '{0, 1, 0, 1, 0, 1, 0, 1};
    localparam int V_ST   [NV] = '{0, 0, 0, 0, 1, -1, -1, 1};

    always @(negedge clk) begin
        if (!rst && bit_valid_o) begin
            if (ng < 32) got[ng] = bit_o;
            ng = ng + 1;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send_bits(input int ln, input logic [15:0] bits, input int n, input int st);
        for (int i = 0; i < n; i++) begin
            int h1;
            h1 = 2;
            if (i % 2 == 1) h1 = 2 + st;
            line[ln] = ~bits[i];
            repeat (h1) @(negedge clk);
            line[ln] = bits[i];
            repeat (2) @(negedge clk);
        end
        line[ln] = 1'b0;
    endtask

    function automatic logic [31:0] lowmask(input int n);
        return (32'h1 << n) - 32'h1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 sel", 32'(sel_o), 32'd0);
        check("R1 idle", 32'(line_idle_o), 32'd1);
        check("R1 locked", 32'(locked_o), 32'd0);
        check("R1 strobe", 32'(bit_valid_o), 32'd0);

        // Table of bursts: R2 R4 R5 R6 R8
        for (int k = 0; k < NV; k++) begin
            ng = 0; got = '0;
            send_bits(V_LINE[k], V_BITS[k], V_LEN[k], V_ST[k]);
            repeat (20) @(negedge clk);
            check("R2 bit count", 32'(ng), 32'(V_LEN[k]));
            check(V_ST[k] != 0 ? "R5 bits" : "R4 bits", got & lowmask(V_LEN[k]),
                  32'(V_BITS[k]) & lowmask(V_LEN[k]));
            check("R6 select", 32'(sel_o), 32'(V_LINE[k]));
            check("R8 idle after burst", 32'(line_idle_o), 32'd1);
        end

        // R3 and R8: single one on wire 0, then idle timing window
        ng = 0; got = '0;
        line[0] = 1'b0; repeat (2) @(negedge clk);
        line[0] = 1'b1; repeat (2) @(negedge clk);
        line[0] = 1'b0;
        repeat (8) @(negedge clk);
        check("R8 not idle at 8", 32'(line_idle_o), 32'd0);
        check("R3 locked on first rise", 32'(locked_o), 32'd1);
        repeat (6) @(negedge clk);
        check("R8 idle by 14", 32'(line_idle_o), 32'd1);
        check("R3 single one", {got[0], 31'(ng)}, {1'b1, 31'd1});
        check("R8 lock dropped", 32'(locked_o), 32'd0);

        // R7: pulse on wire 1 in the middle of a burst on wire 0
        ng = 0; got = '0;
        fork
            send_bits(0, 16'h1C35, 16, 0);
            begin
                repeat (20) @(negedge clk);
                line[1] = 1'b1; @(negedge clk);
                line[1] = 1'b0;
                repeat (6) @(negedge clk);
                check("R7 select held mid-burst", 32'(sel_o), 32'd0);
            end
        join
        repeat (20) @(negedge clk);
        check("R7 bits intact", got & lowmask(16), 32'h1C35);
        check("R7 count", 32'(ng), 32'd16);
        check("R7 select after", 32'(sel_o), 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule